// File: doc/BRIEF.md
# Dual Stack Pointer Engine

This block owns the two byte-wide stack pointers of a small processor core and performs the RAM traffic that goes with them. The return stack pointer starts at address zero and grows upward. A subroutine call or an interrupt entry stores the 14-bit return address and the carry and zero flags there as two bytes. A return or an interrupt return reads them back. The operand stack pointer serves push and pop. It moves downward on push and upward on pop.

The decoder presents one command at a time on `opValid`/`opCode`, together with the values it needs: program counter and flags, push data, or a new pointer value. The engine drives a single RAM port with a combinational read path. It raises `busy` for each cycle in which it uses that port. After the last RAM cycle it gives a one-cycle `done`, and the restored program counter, the flags or the popped byte are valid at that time. It also tells the interrupt logic when to mask interrupts (on entry) and when to unmask them (on interrupt return).

Top module: `stack_ptr_engine`

## Requirements
- R1: After reset both pointers read 0x00, `busy`, `done`, `intEnClr` and `intEnSet` are low, and `pcOut`, `carryOut` and `zeroOut` are zero.
- R2: Command 1 (call) and command 2 (interrupt entry) take two busy cycles. The first cycle writes pcIn[7:0] at the return pointer. The second writes {carryIn, zeroIn, pcIn[13:8]} (carry in bit 7, zero in bit 6) at the pointer plus one. The return pointer ends two higher.
- R3: Command 2 pulses `intEnClr` in its first write cycle; command 1 never raises it.
- R4: Command 4 (interrupt return) reads the flags/high byte at return pointer minus one, then the low byte at minus two. In its `done` cycle `pcOut`, `carryOut` and `zeroOut` hold the restored values, `intEnSet` pulses, and the pointer is two lower.
- R5: Command 3 (plain return) follows the same two reads and updates `pcOut`. `carryOut` and `zeroOut` keep their previous values and `intEnSet` stays low.
- R6: Command 5 (push) takes one busy cycle. It decrements the operand pointer and writes `pushData` at the new value, so a push at 0x00 writes address 0xFF.
- R7: Command 6 (pop) takes one busy cycle. It reads at the operand pointer, presents the byte on `popData` in the `done` cycle, and increments the pointer, so a pop at 0xFF leaves 0x00.
- R8: Command 7 (load) copies `loadValue` into the return pointer when `loadSel` is 0, or into the operand pointer when it is 1. It raises no busy cycle, touches no RAM, and gives `done` in the next cycle.
- R9: Pointer arithmetic wraps modulo 256. A call with the return pointer at 0xFF writes 0xFF and then 0x00, and leaves the pointer at 0x01.
- R10: `done` is high exactly in the cycle after an operation's last busy cycle. A command presented while `busy` is high is ignored.
- R11: A command presented in a `done` cycle is accepted, and its first busy cycle follows directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Command strobe |
| opCode | input | 3 | Command code (0 none, 1 call, 2 interrupt entry, 3 return, 4 interrupt return, 5 push, 6 pop, 7 load) |
| loadSel | input | 1 | Load target: 0 return pointer, 1 operand pointer |
| loadValue | input | 8 | New pointer value for load |
| pcIn | input | 14 | Return address to save |
| carryIn | input | 1 | Carry flag to save |
| zeroIn | input | 1 | Zero flag to save |
| pushData | input | 8 | Byte to push |
| busy | output | 1 | RAM port in use by the engine |
| done | output | 1 | One-cycle completion pulse |
| intEnClr | output | 1 | Mask interrupts (interrupt entry) |
| intEnSet | output | 1 | Unmask interrupts (interrupt return) |
| ramAddr | output | 8 | RAM address |
| ramWe | output | 1 | RAM write enable |
| ramRe | output | 1 | RAM read strobe |
| ramWdata | output | 8 | RAM write data |
| ramRdata | input | 8 | RAM read data, valid in the same cycle as the address |
| pcOut | output | 14 | Restored program counter |
| carryOut | output | 1 | Restored carry flag |
| zeroOut | output | 1 | Restored zero flag |
| popData | output | 8 | Popped byte |
| pspOut | output | 8 | Return stack pointer |
| dspOut | output | 8 | Operand stack pointer |

## Verification
The one overlap this engine allows is the `done` cycle of one operation together with the acceptance of the next command. A command offered during a busy cycle must instead be dropped. The bench sets up both cases on purpose. It offers a load to the operand pointer during a call's first write cycle and expects the pointer to stay unchanged. In the `done` cycle of that call it offers a push and expects `busy` in the very next cycle, with the byte in RAM just below the operand pointer. A seeded random command stream then runs back-to-back operations against a bench model of the pointers and the RAM.

// File: rtl/stkeng_pkg.sv
package stkeng_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_CALL   = 3'd1,
    OP_INTENT = 3'd2,
    OP_RET    = 3'd3,
    OP_RETI   = 3'd4,
    OP_PUSH   = 3'd5,
    OP_POP    = 3'd6,
    OP_LOAD   = 3'd7
  } stkOp_e;

  typedef enum logic [1:0] {
    AS_RSP    = 2'd0,
    AS_RSP_M1 = 2'd1,
    AS_OSP    = 2'd2,
    AS_OSP_M1 = 2'd3
  } addrSel_e;

  typedef enum logic [1:0] {
    WS_LOW  = 2'd0,
    WS_HIGH = 2'd1,
    WS_PUSH = 2'd2
  } wrSel_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic     capSave;   // latch pc, flags, push byte at accept
    logic     ldRsp;
    logic     ldOsp;
    logic     rspInc;
    logic     rspDec;
    logic     ospInc;
    logic     ospDec;
    addrSel_e addrSel;
    wrSel_e   wrSel;
    logic     ramWe;
    logic     ramRe;
    logic     capHigh;   // keep flags/high byte for second read
    logic     capPc;     // assemble restored pc
    logic     capFlags;  // restore flags too
    logic     capPop;
  } strobe_t;

endpackage

// File: rtl/stkeng_ptr.sv
module stkeng_ptr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ld,
  input  logic         inc,
  input  logic         dec,
  input  logic [W-1:0] ldVal,
  output logic [W-1:0] ptr,
  output logic [W-1:0] ptrM1
);

  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)    ptr <= '0;
    else if (ld)  ptr <= ldVal;
    else if (inc) ptr <= ptr + ONE;
    else if (dec) ptr <= ptr - ONE;
  end

  assign ptrM1 = ptr - ONE;

endmodule

// File: rtl/stkeng_ctrl.sv
module stkeng_ctrl
  import stkeng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       loadSel,
  output strobe_t    stb,
  output logic       busy,
  output logic       done,
  output logic       intEnClr,
  output logic       intEnSet
);

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND, ST_FIN} state_e;

  state_e state, stateNxt;
  stkOp_e curOp, inOp;
  logic   accept;
  logic   saveOp, restoreOp;

  assign inOp      = stkOp_e'(opCode);
  assign accept    = opValid && (inOp != OP_NONE) &&
                     ((state == ST_IDLE) || (state == ST_FIN));
  assign saveOp    = (curOp == OP_CALL) || (curOp == OP_INTENT);
  assign restoreOp = (curOp == OP_RET)  || (curOp == OP_RETI);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE, ST_FIN: begin
        if (accept) stateNxt = (inOp == OP_LOAD) ? ST_FIN : ST_FIRST;
        else        stateNxt = ST_IDLE;
      end
      ST_FIRST:  stateNxt = (saveOp || restoreOp) ? ST_SECOND : ST_FIN;
      ST_SECOND: stateNxt = ST_FIN;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curOp <= OP_NONE;
    end else begin
      state <= stateNxt;
      if (accept) curOp <= inOp;
    end
  end

  always_comb begin
    stb         = '0;
    stb.addrSel = AS_RSP;
    stb.wrSel   = WS_LOW;
    stb.capSave = accept;
    stb.ldRsp   = accept && (inOp == OP_LOAD) && !loadSel;
    stb.ldOsp   = accept && (inOp == OP_LOAD) &&  loadSel;
    if (state == ST_FIRST) begin
      unique case (curOp)
        OP_CALL, OP_INTENT: begin
          stb.addrSel = AS_RSP;
          stb.wrSel   = WS_LOW;
          stb.ramWe   = 1'b1;
          stb.rspInc  = 1'b1;
        end
        OP_RET, OP_RETI: begin
          stb.addrSel = AS_RSP_M1;
          stb.ramRe   = 1'b1;
          stb.capHigh = 1'b1;
          stb.rspDec  = 1'b1;
        end
        OP_PUSH: begin
          stb.addrSel = AS_OSP_M1;
          stb.wrSel   = WS_PUSH;
          stb.ramWe   = 1'b1;
          stb.ospDec  = 1'b1;
        end
        OP_POP: begin
          stb.addrSel = AS_OSP;
          stb.ramRe   = 1'b1;
          stb.capPop  = 1'b1;
          stb.ospInc  = 1'b1;
        end
        default: ;
      endcase
    end else if (state == ST_SECOND) begin
      if (saveOp) begin
        stb.addrSel = AS_RSP;
        stb.wrSel   = WS_HIGH;
        stb.ramWe   = 1'b1;
        stb.rspInc  = 1'b1;
      end else if (restoreOp) begin
        stb.addrSel  = AS_RSP_M1;
        stb.ramRe    = 1'b1;
        stb.capPc    = 1'b1;
        stb.capFlags = (curOp == OP_RETI);
        stb.rspDec   = 1'b1;
      end
    end
  end

  assign busy     = (state == ST_FIRST) || (state == ST_SECOND);
  assign done     = (state == ST_FIN);
  assign intEnClr = (state == ST_FIRST) && (curOp == OP_INTENT);
  assign intEnSet = (state == ST_FIN)   && (curOp == OP_RETI);

endmodule

// File: rtl/stkeng_dp.sv
module stkeng_dp
  import stkeng_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PC_W   = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] loadValue,
  input  logic [PC_W-1:0]   pcIn,
  input  logic              carryIn,
  input  logic              zeroIn,
  input  logic [DATA_W-1:0] pushData,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  output logic [PC_W-1:0]   pcOut,
  output logic              carryOut,
  output logic              zeroOut,
  output logic [DATA_W-1:0] popData,
  output logic [ADDR_W-1:0] rspOut,
  output logic [ADDR_W-1:0] ospOut
);

  localparam int HI_W   = PC_W - DATA_W;
  localparam int N_PTR  = 2;
  localparam int IX_RSP = 0;
  localparam int IX_OSP = 1;

  logic [N_PTR-1:0]  ldV, incV, decV;
  logic [ADDR_W-1:0] ptrV   [N_PTR];
  logic [ADDR_W-1:0] ptrM1V [N_PTR];

  assign ldV[IX_RSP]  = stb.ldRsp;
  assign ldV[IX_OSP]  = stb.ldOsp;
  assign incV[IX_RSP] = stb.rspInc;
  assign incV[IX_OSP] = stb.ospInc;
  assign decV[IX_RSP] = stb.rspDec;
  assign decV[IX_OSP] = stb.ospDec;

  for (genvar g = 0; g < N_PTR; g++) begin : gPtr
    stkeng_ptr #(.W(ADDR_W)) u_ptr (
      .clk   (clk),
      .rstN  (rstN),
      .ld    (ldV[g]),
      .inc   (incV[g]),
      .dec   (decV[g]),
      .ldVal (loadValue),
      .ptr   (ptrV[g]),
      .ptrM1 (ptrM1V[g])
    );
  end

  assign rspOut = ptrV[IX_RSP];
  assign ospOut = ptrV[IX_OSP];

  logic [PC_W-1:0]   savePc;
  logic              saveC, saveZ;
  logic [DATA_W-1:0] pushReg;
  logic [DATA_W-1:0] highReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savePc  <= '0;
      saveC   <= 1'b0;
      saveZ   <= 1'b0;
      pushReg <= '0;
    end else if (stb.capSave) begin
      savePc  <= pcIn;
      saveC   <= carryIn;
      saveZ   <= zeroIn;
      pushReg <= pushData;
    end
  end

  always_comb begin
    unique case (stb.addrSel)
      AS_RSP:    ramAddr = ptrV[IX_RSP];
      AS_RSP_M1: ramAddr = ptrM1V[IX_RSP];
      AS_OSP:    ramAddr = ptrV[IX_OSP];
      default:   ramAddr = ptrM1V[IX_OSP];
    endcase
  end

  always_comb begin
    unique case (stb.wrSel)
      WS_LOW:  ramWdata = savePc[DATA_W-1:0];
      WS_HIGH: ramWdata = {saveC, saveZ, savePc[PC_W-1:DATA_W]};
      default: ramWdata = pushReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highReg  <= '0;
      pcOut    <= '0;
      carryOut <= 1'b0;
      zeroOut  <= 1'b0;
      popData  <= '0;
    end else begin
      if (stb.capHigh) highReg <= ramRdata;
      if (stb.capPc)   pcOut   <= {highReg[HI_W-1:0], ramRdata};
      if (stb.capFlags) begin
        carryOut <= highReg[DATA_W-1];
        zeroOut  <= highReg[DATA_W-2];
      end
      if (stb.capPop)  popData <= ramRdata;
    end
  end

endmodule

// File: rtl/stack_ptr_engine.sv
module stack_ptr_engine
  import stkeng_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PC_W   = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic              loadSel,
  input  logic [ADDR_W-1:0] loadValue,
  input  logic [PC_W-1:0]   pcIn,
  input  logic              carryIn,
  input  logic              zeroIn,
  input  logic [DATA_W-1:0] pushData,
  output logic              busy,
  output logic              done,
  output logic              intEnClr,
  output logic              intEnSet,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic              ramRe,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [PC_W-1:0]   pcOut,
  output logic              carryOut,
  output logic              zeroOut,
  output logic [DATA_W-1:0] popData,
  output logic [ADDR_W-1:0] pspOut,
  output logic [ADDR_W-1:0] dspOut
);

  strobe_t stb;

  stkeng_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opCode   (opCode),
    .loadSel  (loadSel),
    .stb      (stb),
    .busy     (busy),
    .done     (done),
    .intEnClr (intEnClr),
    .intEnSet (intEnSet)
  );

  stkeng_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .loadValue (loadValue),
    .pcIn      (pcIn),
    .carryIn   (carryIn),
    .zeroIn    (zeroIn),
    .pushData  (pushData),
    .ramRdata  (ramRdata),
    .ramAddr   (ramAddr),
    .ramWdata  (ramWdata),
    .pcOut     (pcOut),
    .carryOut  (carryOut),
    .zeroOut   (zeroOut),
    .popData   (popData),
    .rspOut    (pspOut),
    .ospOut    (dspOut)
  );

  assign ramWe = stb.ramWe;
  assign ramRe = stb.ramRe;

endmodule

// File: rtl/stack_ptr_engine_chk.sv
module stack_ptr_engine_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opCode,
  input logic              busy,
  input logic              done,
  input logic              intEnClr,
  input logic              intEnSet,
  input logic              ramWe,
  input logic              ramRe,
  input logic [ADDR_W-1:0] ramAddr
);

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN) ramWe |-> busy); // R2
  AST_SAVE_ADDR_UP: assert property (@(posedge clk) disable iff (!rstN) (ramWe && $past(ramWe)) |-> (ramAddr == ADDR_W'($past(ramAddr) + 1'b1))); // R2
  AST_RESTORE_ADDR_DOWN: assert property (@(posedge clk) disable iff (!rstN) (ramRe && $past(ramRe)) |-> (ramAddr == ADDR_W'($past(ramAddr) - 1'b1))); // R4
  AST_MASK_WITH_WRITE: assert property (@(posedge clk) disable iff (!rstN) intEnClr |-> (ramWe && busy)); // R3
  AST_UNMASK_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN) intEnSet |-> (done && !busy)); // R4
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> done); // R10
  AST_READ_WRITE_EXCL: assert property (@(posedge clk) disable iff (!rstN) ramWe |-> !ramRe); // R6
  AST_LOAD_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN) (opValid && opCode == 3'd7 && !busy) |=> (!busy && done)); // R8

endmodule

bind stack_ptr_engine stack_ptr_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opCode   (opCode),
  .busy     (busy),
  .done     (done),
  .intEnClr (intEnClr),
  .intEnSet (intEnSet),
  .ramWe    (ramWe),
  .ramRe    (ramRe),
  .ramAddr  (ramAddr)
);

// File: tb/stack_ptr_engine_test.sv
module stack_ptr_engine_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic        loadSel = 1'b0;
  logic [7:0]  loadValue = 8'd0;
  logic [13:0] pcIn = 14'd0;
  logic        carryIn = 1'b0;
  logic        zeroIn = 1'b0;
  logic [7:0]  pushData = 8'd0;
  logic        busy, done, intEnClr, intEnSet, ramWe, ramRe;
  logic [7:0]  ramAddr, ramWdata, ramRdata, popData, pspOut, dspOut;
  logic [13:0] pcOut;
  logic        carryOut, zeroOut;

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0] ram  [256];
  logic [7:0] mMem [256];
  logic [7:0] mPsp, mDsp, mPop;
  logic [13:0] mPc;
  logic mC, mZ;

  int   busyCnt;
  logic sawClr, sawSet, sawDone;

  always #5 clk = ~clk;

  stack_ptr_engine uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .loadSel(loadSel), .loadValue(loadValue), .pcIn(pcIn),
    .carryIn(carryIn), .zeroIn(zeroIn), .pushData(pushData),
    .busy(busy), .done(done), .intEnClr(intEnClr), .intEnSet(intEnSet),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramRe(ramRe), .ramWdata(ramWdata),
    .ramRdata(ramRdata), .pcOut(pcOut), .carryOut(carryOut),
    .zeroOut(zeroOut), .popData(popData), .pspOut(pspOut), .dspOut(dspOut)
  );

  assign ramRdata = ram[ramAddr];
  always @(posedge clk) if (ramWe) ram[ramAddr] <= ramWdata;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hiByte(input logic c, input logic z, input logic [13:0] pc);
    return {c, z, pc[13:8]};
  endfunction

  // bench model of one command, applied from the requirements
  task automatic modelApply(input logic [2:0] op, input logic sel, input logic [7:0] lv,
                            input logic [13:0] pc, input logic c, input logic z,
                            input logic [7:0] pd);
    logic [7:0] h, l;
    case (op)
      3'd1, 3'd2: begin
        mMem[mPsp] = pc[7:0];
        mMem[8'(mPsp + 8'd1)] = hiByte(c, z, pc);
        mPsp = mPsp + 8'd2;
      end
      3'd3, 3'd4: begin
        h = mMem[8'(mPsp - 8'd1)];
        l = mMem[8'(mPsp - 8'd2)];
        mPc = {h[5:0], l};
        if (op == 3'd4) begin mC = h[7]; mZ = h[6]; end
        mPsp = mPsp - 8'd2;
      end
      3'd5: begin mDsp = mDsp - 8'd1; mMem[mDsp] = pd; end
      3'd6: begin mPop = mMem[mDsp]; mDsp = mDsp + 8'd1; end
      3'd7: if (sel) mDsp = lv; else mPsp = lv;
      default: ;
    endcase
  endtask

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R4";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int expBusy(input logic [2:0] op);
    if (op == 3'd7) return 0;
    if (op == 3'd5 || op == 3'd6) return 1;
    return 2;
  endfunction

  // drive one command at a falling edge and follow it to its done cycle
  task automatic runOp(input logic [2:0] op, input logic sel, input logic [7:0] lv,
                       input logic [13:0] pc, input logic c, input logic z,
                       input logic [7:0] pd);
    @(negedge clk);
    opValid = 1'b1; opCode = op; loadSel = sel; loadValue = lv;
    pcIn = pc; carryIn = c; zeroIn = z; pushData = pd;
    @(negedge clk);
    opValid = 1'b0;
    busyCnt = 0; sawClr = 1'b0; sawSet = 1'b0; sawDone = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (done) begin sawDone = 1'b1; break; end
      if (busy) busyCnt++;
      if (intEnClr) sawClr = 1'b1;
      @(negedge clk);
    end
    sawSet = intEnSet;
  endtask

  task automatic checkModel(input string req);
    chk(req, int'(pspOut), int'(mPsp));
    chk(req, int'(dspOut), int'(mDsp));
    chk(req, int'(pcOut), int'(mPc));
    chk(req, int'(carryOut), int'(mC));
    chk(req, int'(zeroOut), int'(mZ));
  endtask

  task automatic doOp(input logic [2:0] op, input logic sel, input logic [7:0] lv,
                      input logic [13:0] pc, input logic c, input logic z,
                      input logic [7:0] pd);
    string t;
    t = tagOf(op);
    runOp(op, sel, lv, pc, c, z, pd);
    modelApply(op, sel, lv, pc, c, z, pd);
    chk("R10", int'(sawDone), 1);
    chk(t, busyCnt, expBusy(op));
    chk("R3", int'(sawClr), int'(op == 3'd2));
    chk("R4", int'(sawSet), int'(op == 3'd4));
    checkModel(t);
    if (op == 3'd6) chk("R7", int'(popData), int'(mPop));
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R10: watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [2:0] op;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; mMem[i] = 8'h00; end
    mPsp = 0; mDsp = 0; mPc = 0; mC = 0; mZ = 0; mPop = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", int'(pspOut), 0);
    chk("R1", int'(dspOut), 0);
    chk("R1", int'(busy), 0);
    chk("R1", int'(done), 0);
    chk("R1", int'(intEnClr | intEnSet), 0);
    chk("R1", int'({pcOut, carryOut, zeroOut}), 0);
    rstN = 1'b1;

    // R2 call: byte order and packing
    doOp(3'd1, 0, 0, 14'h2A5C, 1'b1, 1'b0, 0);
    chk("R2", int'(ram[0]), 'h5C);
    chk("R2", int'(ram[1]), 'hAA);
    // R3 interrupt entry masks interrupts
    doOp(3'd2, 0, 0, 14'h1234, 1'b0, 1'b1, 0);
    chk("R3", int'(ram[2]), 'h34);
    chk("R3", int'(ram[3]), 'h52);
    // R5 plain return keeps flags at zero
    doOp(3'd3, 0, 0, 0, 0, 0, 0);
    chk("R5", int'(pcOut), 'h1234);
    chk("R5", int'({carryOut, zeroOut}), 0);
    // R4 interrupt return restores flags
    doOp(3'd4, 0, 0, 0, 0, 0, 0);
    chk("R4", int'(pcOut), 'h2A5C);
    chk("R4", int'({carryOut, zeroOut}), 'b10);
    // R6 push at zero wraps to top address
    doOp(3'd5, 0, 0, 0, 0, 0, 8'h77);
    chk("R6", int'(ram[255]), 'h77);
    chk("R6", int'(dspOut), 'hFF);
    // R7 pop at 0xFF wraps to zero
    doOp(3'd6, 0, 0, 0, 0, 0, 0);
    chk("R7", int'(popData), 'h77);
    chk("R7", int'(dspOut), 0);
    // R8 load, R9 wrap of the return pointer
    doOp(3'd7, 1'b0, 8'hFF, 0, 0, 0, 0);
    chk("R8", int'(pspOut), 'hFF);
    doOp(3'd1, 0, 0, 14'h3FFF, 1'b0, 1'b1, 0);
    chk("R9", int'(ram[255]), 'hFF);
    chk("R9", int'(ram[0]), 'h7F);
    chk("R9", int'(pspOut), 'h01);

    // R10 command during busy is dropped, R11 command in done cycle is taken
    @(negedge clk);
    opValid = 1'b1; opCode = 3'd1; pcIn = 14'h0ABC; carryIn = 1'b1; zeroIn = 1'b1;
    @(negedge clk);
    chk("R10", int'(busy), 1);
    opCode = 3'd7; loadSel = 1'b1; loadValue = 8'h55;
    @(negedge clk);
    opValid = 1'b0;
    @(negedge clk);
    chk("R10", int'(done), 1);
    modelApply(3'd1, 0, 0, 14'h0ABC, 1'b1, 1'b1, 0);
    checkModel("R10");
    opValid = 1'b1; opCode = 3'd5; pushData = 8'h11;
    @(negedge clk);
    chk("R11", int'(busy), 1);
    opValid = 1'b0;
    @(negedge clk);
    chk("R11", int'(done), 1);
    modelApply(3'd5, 0, 0, 0, 0, 0, 8'h11);
    checkModel("R11");
    chk("R11", int'(ram[dspOut]), 'h11);

    // seeded random command stream against the model
    for (int n = 0; n < 400; n++) begin
      op = 3'($urandom_range(1, 7));
      doOp(op, 1'($urandom), 8'($urandom), 14'($urandom), 1'($urandom),
           1'($urandom), 8'($urandom));
    end
    finishRun();
  end

endmodule